// File: doc/BRIEF.md
# Strided and Indexed Stream Address Generator

This block turns one stream transfer command into the ordered list of word addresses that a memory load or store of that stream touches. It does not hold transfer parameters in the command. Software first writes them into a small file of descriptor entries. Each entry holds a start address, a signed record-to-record step, a record size in words and a total length in words. A command then names an entry by its number and chooses between two addressing modes.

In strided mode the generator emits runs of consecutive words, one run per record. Each new run begins one step beyond the start of the previous run. In indexed mode the generator takes one offset from a separate offset stream for each element and emits start address plus offset. The offset stream gives gather or scatter access to arbitrary locations.

Addresses leave on a valid/ready channel and are issued back to back, without waiting for data to return. A one-cycle completion pulse follows the last accepted address. A memory system that needs two concurrent transfers places two copies of the block side by side.

The controller is a five-state machine:
- IDLE accepts a command. It moves to FINISH when the selected length is zero, to GFETCH for an indexed command, and to STRIDE otherwise.
- STRIDE presents strided addresses and moves to FINISH when the last word is accepted.
- GFETCH waits for an offset and moves to GISSUE when one arrives.
- GISSUE presents an indexed address. When that address is accepted it moves to FINISH if it was the last one. Otherwise it stays in GISSUE if the next offset arrives in the same cycle, and falls back to GFETCH if it does not.
- FINISH raises the completion pulse and returns to IDLE.

Top module: `stream_agen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_valid` and `done` are 0 and `cmd_ready` is 1.
- R2: There are 8 descriptor entries. A write with `desc_wr_en`=1 stores the base (24 bits), the stride (16-bit two's complement), the record size (5 bits) and the length (16 bits) into the entry `desc_wr_sel`, taking effect at that clock edge. An accepted command uses the entry numbered `cmd_sel`.
- R3: In strided mode (`cmd_indexed`=0), word k of the stream has address (base + floor(k/S)*stride + (k mod S)) mod 2^24. S is the effective record size: a record size of 0 counts as 1, and a value above 16 counts as 16.
- R4: The stride is sign-extended to 24 bits before it is added, so a negative stride walks downward and wraps modulo 2^24.
- R5: Exactly `length` addresses are issued per command, and a final partial record is cut off at that count. A length of 0 issues no address and still gives the completion pulse.
- R6: In indexed mode (`cmd_indexed`=1), element k has address (base + zero-extended offset k) mod 2^24. The offsets are consumed in arrival order, exactly one per address, and the stride and record size have no effect.
- R7: While `req_valid`=1 and `req_ready`=0, `req_valid` stays 1 and `req_addr` keeps its value on the next cycle. The address advances only on a cycle where valid and ready are both 1.
- R8: In strided mode `req_valid` is 1 in every cycle from the cycle after command acceptance until the last address is accepted, so one address per cycle is issued when `req_ready` is held at 1.
- R9: A descriptor write to the entry in use by the running stream does not change that stream's addresses. It applies from the next command that selects the entry.
- R10: `done` is 1 for exactly one cycle, in the cycle after the last address handshake (or after acceptance for a zero-length command). `cmd_ready` is 0 from the cycle after acceptance through that `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| desc_wr_en | input | 1 | Descriptor write strobe |
| desc_wr_sel | input | 3 | Descriptor entry being written |
| desc_wr_base | input | 24 | Start word address |
| desc_wr_stride | input | 16 | Signed distance between record starts, in words |
| desc_wr_recsz | input | 5 | Words per record (0 counts as 1, above 16 counts as 16) |
| desc_wr_len | input | 16 | Total words in the stream |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Generator idle and able to take a command |
| cmd_sel | input | 3 | Descriptor entry used by the command |
| cmd_indexed | input | 1 | 1 selects indexed mode, 0 selects strided mode |
| idx_valid | input | 1 | Offset available |
| idx_ready | output | 1 | Offset taken this cycle when valid |
| idx_off | input | 16 | Unsigned word offset for indexed mode |
| req_valid | output | 1 | Address request present |
| req_ready | input | 1 | Downstream accepts the address |
| req_addr | output | 24 | Word address |
| done | output | 1 | One-cycle completion pulse |

## Verification
Strided streams are run with these record shapes:
- Unit stride with single-word records.
- A stride of 12 with 4-word records and a length that leaves a 2-word tail, which separates correct truncation from issuing a whole last record.
- A negative stride that crosses address zero, which exposes a missing sign extension.
- Out-of-range record sizes, which expose a missing clamp.

Each shape runs once with the downstream always ready, to expose any bubble in back-to-back issue. It runs again with ready toggling randomly, to expose an address that moves while stalled.

Indexed streams are fed both with an offset present every cycle and with a randomly gapped offset stream. These show whether an offset can be skipped or reused when an address handshake and an offset handshake fall in the same cycle.

A zero-length command shows that completion does not depend on issuing any address. A rewrite of the running entry in the middle of a stream, followed by a second command on that entry, separates an early snapshot from a live read of the descriptor.

// File: rtl/stream_agen_pkg.sv
package stream_agen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_STRIDE = 3'd1,
        ST_GFETCH = 3'd2,
        ST_GISSUE = 3'd3,
        ST_FINISH = 3'd4
    } agen_state_e;

endpackage

// File: rtl/stream_agen_descfile.sv
module stream_agen_descfile #(
    parameter int NDESC  = 8,
    parameter int ADDR_W = 24,
    parameter int STR_W  = 16,
    parameter int RS_W   = 5,
    parameter int LEN_W  = 16,
    localparam int SEL_W = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [STR_W-1:0]  wr_stride,
    input  logic [RS_W-1:0]   wr_rs,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [ADDR_W-1:0] rd_base,
    output logic [STR_W-1:0]  rd_stride,
    output logic [RS_W-1:0]   rd_rs,
    output logic [LEN_W-1:0]  rd_len
);

    logic [ADDR_W-1:0] base_r   [NDESC];
    logic [STR_W-1:0]  stride_r [NDESC];
    logic [RS_W-1:0]   rs_r     [NDESC];
    logic [LEN_W-1:0]  len_r    [NDESC];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NDESC; i++) begin
                base_r[i]   <= '0;
                stride_r[i] <= '0;
                rs_r[i]     <= '0;
                len_r[i]    <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NDESC; i++) begin
                if (wr_sel == SEL_W'(i)) begin
                    base_r[i]   <= wr_base;
                    stride_r[i] <= wr_stride;
                    rs_r[i]     <= wr_rs;
                    len_r[i]    <= wr_len;
                end
            end
        end
    end

    assign rd_base   = base_r[rd_sel];
    assign rd_stride = stride_r[rd_sel];
    assign rd_rs     = rs_r[rd_sel];
    assign rd_len    = len_r[rd_sel];

endmodule

// File: rtl/stream_agen_ctrl.sv
module stream_agen_ctrl
    import stream_agen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_indexed,
    input  logic        len_zero,
    input  logic        last,
    input  logic        req_ready,
    input  logic        idx_valid,
    output logic        cmd_ready,
    output logic        req_valid,
    output logic        idx_ready,
    output logic        done,
    output logic        load,
    output logic        step,
    output logic        fetch
);

    agen_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (len_zero)         state_d = ST_FINISH;
                    else if (cmd_indexed) state_d = ST_GFETCH;
                    else                  state_d = ST_STRIDE;
                end
            end
            ST_STRIDE: begin
                if (req_ready && last) state_d = ST_FINISH;
            end
            ST_GFETCH: begin
                if (idx_valid) state_d = ST_GISSUE;
            end
            ST_GISSUE: begin
                if (req_ready) begin
                    if (last)           state_d = ST_FINISH;
                    else if (idx_valid) state_d = ST_GISSUE;
                    else                state_d = ST_GFETCH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready = 1'b0;
        req_valid = 1'b0;
        idx_ready = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   cmd_ready = 1'b1;
            ST_STRIDE: req_valid = 1'b1;
            ST_GFETCH: idx_ready = 1'b1;
            ST_GISSUE: begin
                req_valid = 1'b1;
                idx_ready = req_ready && !last;
            end
            ST_FINISH: done = 1'b1;
            default:   cmd_ready = 1'b0;
        endcase
    end

    assign load  = cmd_ready && cmd_valid;
    assign step  = req_valid && req_ready;
    assign fetch = idx_ready && idx_valid;

endmodule

// File: rtl/stream_agen_addr.sv
module stream_agen_addr #(
    parameter int ADDR_W  = 24,
    parameter int STR_W   = 16,
    parameter int RS_W    = 5,
    parameter int LEN_W   = 16,
    parameter int OFF_W   = 16,
    parameter int MAX_REC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              fetch,
    input  logic              cmd_indexed,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [STR_W-1:0]  desc_stride,
    input  logic [RS_W-1:0]   desc_rs,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic [OFF_W-1:0]  idx_off,
    output logic [ADDR_W-1:0] addr,
    output logic              last,
    output logic              len_zero
);

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    logic [ADDR_W-1:0] base_q, rec_q, cur_q, stride_x, off_x, next_rec;
    logic [STR_W-1:0]  stride_q;
    logic [RS_W-1:0]   rs_q, wcnt_q, rs_eff;
    logic [LEN_W-1:0]  rem_q;
    logic              indexed_q;

    always_comb begin
        if (desc_rs == '0)                   rs_eff = RS_W'(1);
        else if (desc_rs > RS_W'(MAX_REC))   rs_eff = RS_W'(MAX_REC);
        else                                 rs_eff = desc_rs;
    end

    assign stride_x = {{(ADDR_W-STR_W){stride_q[STR_W-1]}}, stride_q};
    assign off_x    = {{(ADDR_W-OFF_W){1'b0}}, idx_off};
    assign next_rec = rec_q + stride_x;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            rec_q     <= '0;
            cur_q     <= '0;
            stride_q  <= '0;
            rs_q      <= RS_W'(1);
            wcnt_q    <= '0;
            rem_q     <= '0;
            indexed_q <= 1'b0;
        end else if (load) begin
            base_q    <= desc_base;
            rec_q     <= desc_base;
            cur_q     <= desc_base;
            stride_q  <= desc_stride;
            rs_q      <= rs_eff;
            wcnt_q    <= '0;
            rem_q     <= desc_len;
            indexed_q <= cmd_indexed;
        end else begin
            if (step) rem_q <= rem_q - LEN_ONE;
            if (indexed_q) begin
                if (fetch) cur_q <= base_q + off_x;
            end else if (step) begin
                if (wcnt_q == rs_q - RS_W'(1)) begin
                    wcnt_q <= '0;
                    rec_q  <= next_rec;
                    cur_q  <= next_rec;
                end else begin
                    wcnt_q <= wcnt_q + RS_W'(1);
                    cur_q  <= cur_q + ADDR_W'(1);
                end
            end
        end
    end

    assign addr     = cur_q;
    assign last     = (rem_q == LEN_ONE);
    assign len_zero = (desc_len == '0);

endmodule

// File: rtl/stream_agen.sv
module stream_agen #(
    parameter int NDESC   = 8,
    parameter int ADDR_W  = 24,
    parameter int STR_W   = 16,
    parameter int LEN_W   = 16,
    parameter int OFF_W   = 16,
    parameter int MAX_REC = 16,
    localparam int SEL_W  = $clog2(NDESC),
    localparam int RS_W   = $clog2(MAX_REC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_wr_en,
    input  logic [SEL_W-1:0]  desc_wr_sel,
    input  logic [ADDR_W-1:0] desc_wr_base,
    input  logic [STR_W-1:0]  desc_wr_stride,
    input  logic [RS_W-1:0]   desc_wr_recsz,
    input  logic [LEN_W-1:0]  desc_wr_len,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [SEL_W-1:0]  cmd_sel,
    input  logic              cmd_indexed,
    input  logic              idx_valid,
    output logic              idx_ready,
    input  logic [OFF_W-1:0]  idx_off,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic              done
);

    logic [ADDR_W-1:0] sel_base;
    logic [STR_W-1:0]  sel_stride;
    logic [RS_W-1:0]   sel_rs;
    logic [LEN_W-1:0]  sel_len;
    logic              load, step, fetch, last, len_zero;

    stream_agen_descfile #(
        .NDESC(NDESC), .ADDR_W(ADDR_W), .STR_W(STR_W), .RS_W(RS_W), .LEN_W(LEN_W)
    ) u_desc (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (desc_wr_en),
        .wr_sel    (desc_wr_sel),
        .wr_base   (desc_wr_base),
        .wr_stride (desc_wr_stride),
        .wr_rs     (desc_wr_recsz),
        .wr_len    (desc_wr_len),
        .rd_sel    (cmd_sel),
        .rd_base   (sel_base),
        .rd_stride (sel_stride),
        .rd_rs     (sel_rs),
        .rd_len    (sel_len)
    );

    stream_agen_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_indexed (cmd_indexed),
        .len_zero    (len_zero),
        .last        (last),
        .req_ready   (req_ready),
        .idx_valid   (idx_valid),
        .cmd_ready   (cmd_ready),
        .req_valid   (req_valid),
        .idx_ready   (idx_ready),
        .done        (done),
        .load        (load),
        .step        (step),
        .fetch       (fetch)
    );

    stream_agen_addr #(
        .ADDR_W(ADDR_W), .STR_W(STR_W), .RS_W(RS_W), .LEN_W(LEN_W),
        .OFF_W(OFF_W), .MAX_REC(MAX_REC)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (step),
        .fetch       (fetch),
        .cmd_indexed (cmd_indexed),
        .desc_base   (sel_base),
        .desc_stride (sel_stride),
        .desc_rs     (sel_rs),
        .desc_len    (sel_len),
        .idx_off     (idx_off),
        .addr        (req_addr),
        .last        (last),
        .len_zero    (len_zero)
    );

endmodule

// File: rtl/stream_agen_chk.sv
module stream_agen_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              done
);

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid); // R7

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> $stable(req_addr)); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req_valid && req_ready) || $past(cmd_valid && cmd_ready)); // R10

    AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid || done |-> !cmd_ready); // R10

    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid); // R5

endmodule

bind stream_agen stream_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .done      (done)
);

// File: tb/stream_agen_tb.sv
module stream_agen_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        desc_wr_en = 1'b0;
    logic [2:0]  desc_wr_sel = '0;
    logic [23:0] desc_wr_base = '0;
    logic [15:0] desc_wr_stride = '0;
    logic [4:0]  desc_wr_recsz = '0;
    logic [15:0] desc_wr_len = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_sel = '0;
    logic        cmd_indexed = 1'b0;
    logic        idx_valid = 1'b0;
    logic        idx_ready;
    logic [15:0] idx_off = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [23:0] req_addr;
    logic        done;

    stream_agen u_dut (
        .clk(clk), .rst_n(rst_n),
        .desc_wr_en(desc_wr_en), .desc_wr_sel(desc_wr_sel), .desc_wr_base(desc_wr_base),
        .desc_wr_stride(desc_wr_stride), .desc_wr_recsz(desc_wr_recsz), .desc_wr_len(desc_wr_len),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_sel(cmd_sel), .cmd_indexed(cmd_indexed),
        .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_off(idx_off),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .done(done)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;
    int    d_base [8];
    int    d_str  [8];
    int    d_rs   [8];
    int    d_len  [8];
    int    exp_q [$];
    int    off_q [$];
    bit    busy = 0, exp_done = 0, strided_act = 0, prev_stall = 0;
    logic [23:0] prev_addr = '0;
    int    rdy_mode = 0;
    int    idx_mode = 0;
    string tag = "R3";

    task automatic chk(input string r, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic int clamp_rs(input int r);
        if (r == 0) return 1;
        if (r > 16) return 16;
        return r;
    endfunction

    // one clock: drive at negedge, compare with the model, update the model after the edge
    task automatic tick();
        bit req_hs, idx_hs, cmd_hs, new_done, wr, stall;
        logic [23:0] a;
        @(negedge clk);
        req_ready = (rdy_mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
        idx_valid = (off_q.size() > 0) && ((idx_mode == 0) || ($urandom_range(0, 1) == 1));
        idx_off   = (off_q.size() > 0) ? 16'(off_q[0]) : 16'h0;
        #1;
        chk("R10 cmd_ready", cmd_ready, !busy);
        chk("R10 done", done, exp_done);
        if (req_valid) begin
            if (exp_q.size() == 0) chk("R5 extra address", 1, 0);
            else                   chk(tag, req_addr, exp_q[0] & 24'hFFFFFF);
        end
        if (prev_stall) begin
            chk("R7 valid held", req_valid, 1);
            chk("R7 address held", req_addr, prev_addr);
        end
        if (busy && strided_act && exp_q.size() > 0) chk("R8 back-to-back", req_valid, 1);
        req_hs = req_valid && req_ready;
        idx_hs = idx_valid && idx_ready;
        cmd_hs = cmd_valid && cmd_ready;
        wr     = desc_wr_en;
        stall  = req_valid && !req_ready;
        a      = req_addr;
        @(posedge clk);
        #1;
        if (exp_done) busy = 0;
        new_done = 0;
        if (req_hs && exp_q.size() > 0) begin
            void'(exp_q.pop_front());
            if (exp_q.size() == 0) new_done = 1;
        end
        if (idx_hs && off_q.size() > 0) void'(off_q.pop_front());
        if (cmd_hs) begin
            int s = int'(cmd_sel);
            busy = 1;
            strided_act = !cmd_indexed;
            if (d_len[s] == 0) new_done = 1;
            for (int k = 0; k < d_len[s]; k++) begin
                if (cmd_indexed) exp_q.push_back((d_base[s] + off_q[k]) & 32'hFFFFFF);
                else begin
                    int rs = clamp_rs(d_rs[s]);
                    exp_q.push_back((d_base[s] + (k / rs) * d_str[s] + (k % rs)) & 32'hFFFFFF);
                end
            end
        end
        if (wr) begin
            d_base[desc_wr_sel] = int'(desc_wr_base);
            d_str[desc_wr_sel]  = int'($signed(desc_wr_stride));
            d_rs[desc_wr_sel]   = int'(desc_wr_recsz);
            d_len[desc_wr_sel]  = int'(desc_wr_len);
        end
        prev_stall = stall;
        prev_addr  = a;
        exp_done   = new_done;
    endtask

    task automatic write_desc(input int sel, input int base, input int stride,
                              input int rs, input int len);
        desc_wr_en     = 1'b1;
        desc_wr_sel    = 3'(sel);
        desc_wr_base   = 24'(base);
        desc_wr_stride = 16'(stride);
        desc_wr_recsz  = 5'(rs);
        desc_wr_len    = 16'(len);
        tick();
        desc_wr_en = 1'b0;
    endtask

    task automatic start(input int sel, input bit ind);
        cmd_sel     = 3'(sel);
        cmd_indexed = ind;
        cmd_valid   = 1'b1;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while ((busy || exp_q.size() > 0) && g < 3000) begin
            tick();
            g++;
        end
        if (g >= 3000) chk("watchdog idle", 0, 1);
        tick();
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            d_base[i] = 0; d_str[i] = 0; d_rs[i] = 0; d_len[i] = 0;
        end
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset req_valid", req_valid, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset cmd_ready", cmd_ready, 1);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 after reset req_valid", req_valid, 0);
        chk("R1 after reset cmd_ready", cmd_ready, 1);

        // R2: descriptor entries, each later picked by cmd_sel
        write_desc(0, 'h100, 12, 4, 10);
        write_desc(1, 'h2000, 1, 1, 8);
        write_desc(2, 'h10, -8, 2, 7);
        write_desc(3, 'h500, 77, 3, 6);
        write_desc(4, 'h40, 5, 2, 0);
        write_desc(5, 'h300, 3, 0, 4);
        write_desc(6, 'hFFFFF0, 100, 20, 20);
        write_desc(7, 'h7000, 2, 3, 9);

        // R3/R5: stride 12, record 4, length 10 leaves a partial record; R8 at full ready
        tag = "R3"; rdy_mode = 0; start(0, 0); wait_idle();
        tag = "R2"; rdy_mode = 0; start(7, 0); wait_idle();
        // R7: same shape under a stalling consumer
        tag = "R7"; rdy_mode = 1; start(0, 0); wait_idle();
        // unit stride
        tag = "R3"; rdy_mode = 1; start(1, 0); wait_idle();
        // R4: negative stride wrapping below zero
        tag = "R4"; rdy_mode = 0; start(2, 0); wait_idle();
        tag = "R4"; rdy_mode = 1; start(2, 0); wait_idle();
        // R3: record size clamps (0 -> 1, 20 -> 16), base wraps at top
        tag = "R3"; rdy_mode = 0; start(5, 0); wait_idle();
        tag = "R3"; rdy_mode = 1; start(6, 0); wait_idle();

        // R6: indexed, offsets every cycle, consumer always ready
        tag = "R6"; rdy_mode = 0; idx_mode = 0;
        off_q = '{3, 0, 65535, 17, 17, 1000};
        start(3, 1); wait_idle();
        chk("R6 offsets consumed", off_q.size(), 0);
        // R6: gapped offsets and stalling consumer
        tag = "R6"; rdy_mode = 1; idx_mode = 1;
        off_q = '{9, 8, 7, 40000, 2, 1};
        start(3, 1); wait_idle();
        chk("R6 offsets consumed", off_q.size(), 0);
        idx_mode = 0;

        // R5: zero length gives done with no address
        tag = "R5"; rdy_mode = 0; start(4, 0); wait_idle();

        // R9: rewrite the running entry mid-stream, then reuse it
        tag = "R9"; rdy_mode = 1; start(1, 0);
        tick(); tick();
        write_desc(1, 'h9000, 5, 2, 5);
        wait_idle();
        tag = "R9"; rdy_mode = 0; start(1, 0); wait_idle();

        repeat (3) tick();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule